// File: doc/BRIEF.md
# Smart LCD Parallel Write Interface

This block drives a command-mode LCD panel that keeps its own frame memory. The panel is written over a parallel bus that has an active-low chip select, a register-select line, a write strobe and an 18-bit data bus. A host can hand over one word at a time through a write port. In DMA mode, a pixel stream enters through a 16-word FIFO instead. Each word carries a tag that marks it as a command or as pixel data.

The block cuts each word into one, two or three bus beats. The split depends on the configured command width and data width. Register-select follows the tag: it is low for commands and high for data. Chip select stays low for the whole word. A busy output tells the host when the next word may be written. The write strobe timing is programmable so the bus can match slow panels. The panel latches data on the falling edge of the strobe.

Top module: `slcd_wr_if`

## Requirements
- R1: After reset, `lcd_cs_n` and `lcd_wr_n` are 1, `lcd_rs` is 0, `lcd_db` is 0, `busy` and `overrun` are 0, and `dma_req` is 1.
- R2: `lcd_rs` is 0 on every beat of a word tagged as a command (`host_cmd`=1) and 1 on every beat of a data word. It keeps its value between words.
- R3: `lcd_cs_n` is low from the cycle after a word is accepted until its last beat ends. It is then high for at least one cycle before the next word. `lcd_wr_n` is never low while `lcd_cs_n` is high.
- R4: Each beat drives `lcd_db` with `lcd_wr_n` high for `cfg_hi_cyc` cycles, then holds `lcd_wr_n` low for `cfg_lo_cyc` cycles. A setting of 0 counts as 1. `lcd_db` and `lcd_rs` do not change on the cycle the strobe falls.
- R5: `busy` is 1 from the cycle after a word is accepted until the cycle after its chip-select gap. It is 0 otherwise.
- R6: Command width `cfg_cmd_w` sets how a command word is placed on the bus:
  - 0 sends two beats on `lcd_db[7:0]`: first bits 15:8, then bits 7:0.
  - 1 (and 3) sends bits 15:0 in one beat on `lcd_db[15:0]`.
  - 2 sends one beat with bits 15:8 on `lcd_db[17:10]` and bits 7:0 on `lcd_db[8:1]`. Bits 9 and 0 are zero.
- R7: Data mode `cfg_data_mode` sets how a data word is placed on the bus:
  - 0 sends bits 7:0 in one beat.
  - 1 sends bits 15:8, then 7:0.
  - 2 sends bits 23:16, then 15:8, then 7:0.
  - 3 sends bits 17:9, then 8:0, each on `lcd_db[8:0]`.
  - 4 sends bits 15:0 in one beat.
  - 5 (and 6, 7) sends bits 17:0 in one beat.
  - Bus bits not named in a mode are zero.
- R8: A host write made while `busy` is 1 or while `cfg_dma_en` is 1 is ignored. It sets `overrun`, which only reset clears.
- R9: With `cfg_dma_en`=1, words written through `dma_wr` go out as data words in arrival order. The FIFO holds 16 words. A push into a full FIFO is dropped.
- R10: `dma_req` is 1 exactly when at least 8 FIFO entries are free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cmd_w | input | 2 | Command width code |
| cfg_data_mode | input | 3 | Data width / beat mode code |
| cfg_hi_cyc | input | 4 | Strobe-high (setup) cycles per beat |
| cfg_lo_cyc | input | 4 | Strobe-low cycles per beat |
| cfg_dma_en | input | 1 | Take words from the FIFO instead of the host port |
| host_wr | input | 1 | Host word write strobe |
| host_cmd | input | 1 | Tag: 1 command, 0 data |
| host_word | input | 24 | Host word |
| dma_wr | input | 1 | FIFO push strobe |
| dma_word | input | 24 | Pixel word pushed into the FIFO |
| dma_req | output | 1 | FIFO has room for a burst of 8 |
| busy | output | 1 | A word is being transferred |
| overrun | output | 1 | Sticky flag for an ignored host write |
| lcd_cs_n | output | 1 | Panel chip select, active low |
| lcd_rs | output | 1 | Register select, 0 command / 1 data |
| lcd_wr_n | output | 1 | Write strobe, panel latches on falling edge |
| lcd_db | output | 18 | Panel data bus |

## Verification
The assertions check several bus rules on every cycle:
- the strobe never goes low outside chip select;
- data and register-select hold still across each falling strobe edge;
- chip select rises for at least one cycle between words, and stays high whenever the block is idle;
- the overrun flag never clears on its own;
- a full FIFO does not grow.

Some behaviour only the bench's scenarios can show. This covers the beat slicing for each command width and data mode, and the counts of strobe-high and strobe-low cycles, including the zero-as-one setting. It also covers the rejection of writes made while busy or in DMA mode, the FIFO order, drops at full, and the request threshold. A behavioural model checks all of these cycle by cycle.

// File: rtl/slcd_pkg.sv
package slcd_pkg;
    localparam int WORD_W = 24;
    localparam int BUS_W  = 18;
    localparam int TIME_W = 4;

    localparam logic [1:0] CW_8X2 = 2'd0;
    localparam logic [1:0] CW_18  = 2'd2;

    localparam logic [2:0] DM_8X1 = 3'd0;
    localparam logic [2:0] DM_8X2 = 3'd1;
    localparam logic [2:0] DM_8X3 = 3'd2;
    localparam logic [2:0] DM_9X2 = 3'd3;
    localparam logic [2:0] DM_16  = 3'd4;

    typedef enum logic [1:0] {ST_IDLE, ST_HIGH, ST_LOW, ST_GAP} ser_st_e;

    function automatic logic [1:0] beat_last(input logic cmd, input logic [1:0] cw,
                                             input logic [2:0] dm);
        if (cmd) return (cw == CW_8X2) ? 2'd1 : 2'd0;
        case (dm)
            DM_8X2, DM_9X2: return 2'd1;
            DM_8X3:         return 2'd2;
            default:        return 2'd0;
        endcase
    endfunction

    function automatic logic [BUS_W-1:0] beat_slice(input logic [WORD_W-1:0] w, input logic cmd,
                                                    input logic [1:0] cw, input logic [2:0] dm,
                                                    input logic [1:0] i);
        logic [BUS_W-1:0] s;
        s = '0;
        if (cmd) begin
            if (cw == CW_8X2)     s[7:0] = (i == 2'd0) ? w[15:8] : w[7:0];
            else if (cw == CW_18) s = {w[15:8], 1'b0, w[7:0], 1'b0};
            else                  s[15:0] = w[15:0];
        end else begin
            case (dm)
                DM_8X1: s[7:0] = w[7:0];
                DM_8X2: s[7:0] = (i == 2'd0) ? w[15:8] : w[7:0];
                DM_8X3: s[7:0] = (i == 2'd0) ? w[23:16] : (i == 2'd1) ? w[15:8] : w[7:0];
                DM_9X2: s[8:0] = (i == 2'd0) ? w[17:9] : w[8:0];
                DM_16:  s[15:0] = w[15:0];
                default: s = w[BUS_W-1:0];
            endcase
        end
        return s;
    endfunction
endpackage

// File: rtl/slcd_fifo.sv
module slcd_fifo #(
    parameter int DEPTH = 16,
    parameter int BURST = 8,
    parameter int DW    = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic          empty,
    output logic          req
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } fifo_t;

    fifo_t q, d;
    logic [DW-1:0] mem [DEPTH];
    logic do_push, do_pop;

    always_comb begin
        d       = q;
        do_push = push && (q.cnt != CW'(DEPTH));
        do_pop  = pop && (q.cnt != '0);
        if (do_push) d.wp = (q.wp == AW'(DEPTH - 1)) ? '0 : q.wp + 1'b1;
        if (do_pop)  d.rp = (q.rp == AW'(DEPTH - 1)) ? '0 : q.rp + 1'b1;
        if (do_push && !do_pop)      d.cnt = q.cnt + 1'b1;
        else if (do_pop && !do_push) d.cnt = q.cnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[q.wp] <= push_data;
    end

    assign head  = mem[q.rp];
    assign empty = (q.cnt == '0);
    assign req   = (CW'(DEPTH) - q.cnt) >= CW'(BURST);

    // R9
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.cnt == CW'(DEPTH) && push && !pop) |=> (q.cnt == CW'(DEPTH)));
endmodule

// File: rtl/slcd_beat_ser.sv
module slcd_beat_ser
    import slcd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_cmd_w,
    input  logic [2:0]        cfg_data_mode,
    input  logic [TIME_W-1:0] cfg_hi_cyc,
    input  logic [TIME_W-1:0] cfg_lo_cyc,
    input  logic              start,
    input  logic              start_cmd,
    input  logic [WORD_W-1:0] start_word,
    output logic              busy,
    output logic              cs_n,
    output logic              rs,
    output logic              wr_n,
    output logic [BUS_W-1:0]  db
);
    typedef struct packed {
        ser_st_e           st;
        logic [TIME_W-1:0] cnt;
        logic [1:0]        idx;
        logic [1:0]        last;
        logic [WORD_W-1:0] word;
        logic              cmd;
        logic [1:0]        cw;
        logic [2:0]        dm;
        logic              cs_n;
        logic              rs;
        logic              wr_n;
        logic [BUS_W-1:0]  db;
    } ser_t;

    ser_t q, d;
    logic [TIME_W-1:0] hi_load, lo_load;

    always_comb begin
        hi_load = (cfg_hi_cyc == '0) ? '0 : cfg_hi_cyc - 1'b1;
        lo_load = (cfg_lo_cyc == '0) ? '0 : cfg_lo_cyc - 1'b1;
        d = q;
        case (q.st)
            ST_IDLE: if (start) begin
                d.st   = ST_HIGH;
                d.word = start_word;
                d.cmd  = start_cmd;
                d.cw   = cfg_cmd_w;
                d.dm   = cfg_data_mode;
                d.idx  = '0;
                d.last = beat_last(start_cmd, cfg_cmd_w, cfg_data_mode);
                d.db   = beat_slice(start_word, start_cmd, cfg_cmd_w, cfg_data_mode, 2'd0);
                d.rs   = !start_cmd;
                d.cs_n = 1'b0;
                d.wr_n = 1'b1;
                d.cnt  = hi_load;
            end
            ST_HIGH: begin
                if (q.cnt == '0) begin
                    d.st   = ST_LOW;
                    d.wr_n = 1'b0;
                    d.cnt  = lo_load;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            ST_LOW: begin
                if (q.cnt != '0) begin
                    d.cnt = q.cnt - 1'b1;
                end else if (q.idx == q.last) begin
                    d.st   = ST_GAP;
                    d.cs_n = 1'b1;
                    d.wr_n = 1'b1;
                    d.db   = '0;
                end else begin
                    d.st   = ST_HIGH;
                    d.idx  = q.idx + 1'b1;
                    d.db   = beat_slice(q.word, q.cmd, q.cw, q.dm, q.idx + 1'b1);
                    d.wr_n = 1'b1;
                    d.cnt  = hi_load;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
            q.cs_n <= 1'b1;
            q.wr_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign busy = (q.st != ST_IDLE);
    assign cs_n = q.cs_n;
    assign rs   = q.rs;
    assign wr_n = q.wr_n;
    assign db   = q.db;

    // R3
    strobe_in_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> wr_n);
    // R3
    cs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |=> cs_n);
    // R4
    fall_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wr_n) |-> ($stable(db) && $stable(rs)));
    // R5
    idle_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> cs_n);
endmodule

// File: rtl/slcd_wr_if.sv
module slcd_wr_if
    import slcd_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int FIFO_BURST = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_cmd_w,
    input  logic [2:0]        cfg_data_mode,
    input  logic [TIME_W-1:0] cfg_hi_cyc,
    input  logic [TIME_W-1:0] cfg_lo_cyc,
    input  logic              cfg_dma_en,
    input  logic              host_wr,
    input  logic              host_cmd,
    input  logic [WORD_W-1:0] host_word,
    input  logic              dma_wr,
    input  logic [WORD_W-1:0] dma_word,
    output logic              dma_req,
    output logic              busy,
    output logic              overrun,
    output logic              lcd_cs_n,
    output logic              lcd_rs,
    output logic              lcd_wr_n,
    output logic [BUS_W-1:0]  lcd_db
);
    typedef struct packed {
        logic ovr;
    } top_t;

    top_t q, d;
    logic              fifo_empty, fifo_pop, start, start_cmd;
    logic [WORD_W-1:0] fifo_head, start_word;

    always_comb begin
        d          = q;
        fifo_pop   = cfg_dma_en && !busy && !fifo_empty;
        start      = fifo_pop || (host_wr && !cfg_dma_en && !busy);
        start_cmd  = cfg_dma_en ? 1'b0 : host_cmd;
        start_word = cfg_dma_en ? fifo_head : host_word;
        if (host_wr && (busy || cfg_dma_en)) d.ovr = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign overrun = q.ovr;

    slcd_fifo #(.DEPTH(FIFO_DEPTH), .BURST(FIFO_BURST), .DW(WORD_W)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (dma_wr),
        .push_data (dma_word),
        .pop       (fifo_pop),
        .head      (fifo_head),
        .empty     (fifo_empty),
        .req       (dma_req)
    );

    slcd_beat_ser u_ser (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_cmd_w     (cfg_cmd_w),
        .cfg_data_mode (cfg_data_mode),
        .cfg_hi_cyc    (cfg_hi_cyc),
        .cfg_lo_cyc    (cfg_lo_cyc),
        .start         (start),
        .start_cmd     (start_cmd),
        .start_word    (start_word),
        .busy          (busy),
        .cs_n          (lcd_cs_n),
        .rs            (lcd_rs),
        .wr_n          (lcd_wr_n),
        .db            (lcd_db)
    );

    // R8
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);
endmodule

// File: tb/tb_slcd_wr_if.sv
`timescale 1ns/1ps
module tb_slcd_wr_if;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_cmd_w = '0;
    logic [2:0]  cfg_data_mode = '0;
    logic [3:0]  cfg_hi_cyc = 4'd1, cfg_lo_cyc = 4'd1;
    logic        cfg_dma_en = 1'b0;
    logic        host_wr = 1'b0, host_cmd = 1'b0;
    logic [23:0] host_word = '0;
    logic        dma_wr = 1'b0;
    logic [23:0] dma_word = '0;
    logic        dma_req, busy, overrun, lcd_cs_n, lcd_rs, lcd_wr_n;
    logic [17:0] lcd_db;

    always #2 clk = ~clk;

    slcd_wr_if dut (.*);

    int checks = 0, errors = 0, cycles = 0;

    // behavioural reference model
    logic [23:0] m_fifo[$];
    logic [17:0] m_beats[$];
    int          m_phase = 0;  // 0 idle 1 setup 2 strobe-low 3 gap
    int          m_left  = 0;
    bit e_cs_n = 1, e_wr_n = 1, e_rs = 0, e_ovr = 0;
    logic [17:0] e_db = '0;

    task automatic make_beats(input logic [23:0] w, input bit cmd);
        m_beats.delete();
        if (cmd) begin
            case (cfg_cmd_w)
                2'd0: begin m_beats.push_back({10'd0, w[15:8]}); m_beats.push_back({10'd0, w[7:0]}); end
                2'd2: m_beats.push_back({w[15:8], 1'b0, w[7:0], 1'b0});
                default: m_beats.push_back({2'd0, w[15:0]});
            endcase
        end else begin
            case (cfg_data_mode)
                3'd0: m_beats.push_back({10'd0, w[7:0]});
                3'd1: begin m_beats.push_back({10'd0, w[15:8]}); m_beats.push_back({10'd0, w[7:0]}); end
                3'd2: begin
                    m_beats.push_back({10'd0, w[23:16]});
                    m_beats.push_back({10'd0, w[15:8]});
                    m_beats.push_back({10'd0, w[7:0]});
                end
                3'd3: begin m_beats.push_back({9'd0, w[17:9]}); m_beats.push_back({9'd0, w[8:0]}); end
                3'd4: m_beats.push_back({2'd0, w[15:0]});
                default: m_beats.push_back(w[17:0]);
            endcase
        end
    endtask

    function automatic int eff(input logic [3:0] v);
        return (v == 0) ? 1 : int'(v);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_fifo.delete(); m_beats.delete();
            m_phase = 0; m_left = 0;
            e_cs_n = 1; e_wr_n = 1; e_rs = 0; e_ovr = 0; e_db = '0;
        end else begin
            int fsz;
            fsz = m_fifo.size();
            if (host_wr && (m_phase != 0 || cfg_dma_en)) e_ovr = 1;
            case (m_phase)
                0: begin
                    bit go; logic [23:0] w; bit c;
                    go = 0; w = '0; c = 0;
                    if (cfg_dma_en && fsz > 0) begin go = 1; w = m_fifo.pop_front(); c = 0; end
                    else if (!cfg_dma_en && host_wr) begin go = 1; w = host_word; c = host_cmd; end
                    if (go) begin
                        make_beats(w, c);
                        e_rs = !c; e_cs_n = 0; e_wr_n = 1;
                        e_db = m_beats.pop_front();
                        m_phase = 1; m_left = eff(cfg_hi_cyc);
                    end
                end
                1: begin
                    m_left--;
                    if (m_left == 0) begin m_phase = 2; e_wr_n = 0; m_left = eff(cfg_lo_cyc); end
                end
                2: begin
                    m_left--;
                    if (m_left == 0) begin
                        if (m_beats.size() == 0) begin
                            m_phase = 3; e_cs_n = 1; e_wr_n = 1; e_db = '0;
                        end else begin
                            e_db = m_beats.pop_front(); e_wr_n = 1;
                            m_phase = 1; m_left = eff(cfg_hi_cyc);
                        end
                    end
                end
                default: m_phase = 0;
            endcase
            if (dma_wr && fsz < 16) m_fifo.push_back(dma_word);
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            chk(lcd_cs_n == e_cs_n, "R3 cs_n", int'(lcd_cs_n), int'(e_cs_n));
            chk(lcd_wr_n == e_wr_n, "R4 wr_n", int'(lcd_wr_n), int'(e_wr_n));
            chk(lcd_rs == e_rs, "R2 rs", int'(lcd_rs), int'(e_rs));
            chk(lcd_db == e_db, "R6 R7 R9 db", int'(lcd_db), int'(e_db));
            chk(busy == (m_phase != 0), "R5 busy", int'(busy), int'(m_phase != 0));
            chk(overrun == e_ovr, "R8 overrun", int'(overrun), int'(e_ovr));
            chk(dma_req == ((16 - m_fifo.size()) >= 8), "R10 dma_req",
                int'(dma_req), int'((16 - m_fifo.size()) >= 8));
        end
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic host_send(input bit cmd, input logic [23:0] w);
        @(negedge clk);
        host_wr = 1; host_cmd = cmd; host_word = w;
        @(negedge clk);
        host_wr = 0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (!busy) break;
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(lcd_cs_n && lcd_wr_n && !lcd_rs && lcd_db == 0 && !busy && !overrun && dma_req,
            "R1 reset", {lcd_cs_n, lcd_wr_n, lcd_rs, busy, overrun, dma_req}, 6'b110001);
        rst_n = 1;
        @(negedge clk);
        // R6 command widths
        for (int c = 0; c < 4; c++) begin
            cfg_cmd_w = 2'(c);
            host_send(1, 24'h00A55A + 24'(c));
            wait_idle();
        end
        // R7 data modes, R4 timing variants
        cfg_hi_cyc = 4'd2; cfg_lo_cyc = 4'd3;
        for (int m = 0; m < 8; m++) begin
            cfg_data_mode = 3'(m);
            host_send(0, 24'hC3_96_5A ^ 24'(m * 24'h111111));
            wait_idle();
        end
        cfg_hi_cyc = 4'd0; cfg_lo_cyc = 4'd0;
        cfg_data_mode = 3'd2;
        host_send(0, 24'h123456);
        wait_idle();
        // R8 write while busy
        cfg_hi_cyc = 4'd3; cfg_lo_cyc = 4'd2; cfg_cmd_w = 2'd0;
        host_send(1, 24'h00BEEF);
        host_send(0, 24'hFFFFFF);
        wait_idle();
        // R9 / R10 DMA streaming
        cfg_dma_en = 1; cfg_data_mode = 3'd1; cfg_hi_cyc = 4'd1; cfg_lo_cyc = 4'd1;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            dma_wr = 1; dma_word = 24'h010203 * 24'(k + 1);
        end
        @(negedge clk);
        dma_wr = 0;
        host_send(1, 24'h000011);
        repeat (300) @(negedge clk);
        cfg_data_mode = 3'd5;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            dma_wr = 1; dma_word = 24'h2AAAA5 + 24'(k);
        end
        @(negedge clk);
        dma_wr = 0;
        repeat (100) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule